// File: doc/BRIEF.md
# Instruction Fetch and Next-Address Unit

This block holds the program counter of a single-cycle processor and delivers one 32-bit instruction word in every clock period. The word comes from a small internal instruction store of 256 words. The store is addressed in bytes but organised in words. Its read path is combinational, so the word at the current PC is on the output in the same cycle as the PC.

On every rising edge the PC moves to its successor. Normally the successor is the next word, at PC + 4. When the datapath reports that two compared registers are equal and the control asserts branch select in the same cycle, the successor is instead PC + 4 plus the fetched word's low 16 bits. Those 16 bits are sign-extended and scaled by four, so that negative offsets branch backward.

A synchronous write port lets a testbench or loader fill the store, normally while reset is held. A synchronous active-high reset returns the PC to zero.

Top module: `ifetch_unit`

## Requirements
- R1: `instr_o` equals the stored word at index `pc_o[9:2]` in the same cycle, with no clock edge in between.
- R2: When reset is low and branch select and equality are not both 1, `pc_o` becomes `pc_o + 4` at the next rising edge.
- R3: When reset is low and both `br_sel` and `eq_flag` are 1, `pc_o` becomes `pc_o + 4 + (sign-extended instr_o[15:0] shifted left by 2)` at the next rising edge.
- R4: `br_sel` alone or `eq_flag` alone does not redirect; the next PC is `pc_o + 4`.
- R5: While `rst` is 1 at a rising edge, `pc_o` becomes 0, whatever the branch inputs are.
- R6: `pc_o[1:0]` is 00 after reset and after every update.
- R7: With `pre_we` = 1 at a rising edge, word `pre_addr` takes `pre_data`; with `pre_we` = 0 the store is left unchanged whatever `pre_addr` and `pre_data` carry.
- R8: An offset with bit 15 set branches backward; offset 0xFFFF makes a taken branch return to its own address.
- R9: PC bits above bit 9 do not take part in indexing, so a target 1024 bytes ahead fetches the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the PC |
| br_sel | input | 1 | Branch select from control |
| eq_flag | input | 1 | Operand-equality condition from the datapath |
| pre_we | input | 1 | Store preload write enable |
| pre_addr | input | 8 | Word index written by the preload port |
| pre_data | input | 32 | Word written by the preload port |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction word fetched at `pc_o` |

## Verification
A wrong PC shows on `pc_o` one edge after the update that caused it. Because the PC also indexes the store, the same fault appears on `instr_o` in that cycle. A misread or corrupted store word shows on `instr_o` as soon as the PC selects it. If that word is then used as a taken branch, its offset sends the next PC to a wrong target one edge later. The bench therefore compares both outputs against an independent model on every cycle, so a fault is caught within one cycle of the first time it becomes visible.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    localparam int XLEN      = 32;
    localparam int OFF_W     = 16;
    localparam int WORD_B    = XLEN / 8;
    localparam int BYTE_SH   = $clog2(WORD_B);

    typedef enum logic [0:0] {
        NXT_SEQ = 1'b0,
        NXT_BR  = 1'b1
    } nxt_sel_e;

    typedef struct packed {
        logic [XLEN-1:0] seq_addr;
        logic [XLEN-1:0] br_addr;
        nxt_sel_e        sel;
    } nxt_t;

    // Sign-extend a word offset and scale it to bytes.
    function automatic logic [XLEN-1:0] br_disp(input logic [OFF_W-1:0] off);
        return {{(XLEN-OFF_W-BYTE_SH){off[OFF_W-1]}}, off, {BYTE_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/ifu_imem.sv
module ifu_imem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_idx] <= wr_data;
        end
    end

    assign rd_data = words[rd_idx];

endmodule

// File: rtl/ifu_next_addr.sv
module ifu_next_addr
    import ifu_pkg::*;
(
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic             br_sel,
    input  logic             eq_flag,
    output nxt_t             nxt
);

    logic [XLEN-1:0] inc;

    always_comb begin
        inc          = pc + XLEN'(WORD_B);
        nxt.seq_addr = inc;
        nxt.br_addr  = inc + br_disp(offset);
        nxt.sel      = (br_sel && eq_flag) ? NXT_BR : NXT_SEQ;
    end

endmodule

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
    import ifu_pkg::*;
#(
    parameter int IMEM_WORDS = 256,
    localparam int IDX_W     = $clog2(IMEM_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             br_sel,
    input  logic             eq_flag,
    input  logic             pre_we,
    input  logic [IDX_W-1:0] pre_addr,
    input  logic [XLEN-1:0]  pre_data,
    output logic [XLEN-1:0]  pc_o,
    output logic [XLEN-1:0]  instr_o
);

    logic [IDX_W-1:0] fetch_idx;
    logic [XLEN-1:0]  pc_d;
    nxt_t             nxt;

    assign fetch_idx = pc_o[IDX_W+BYTE_SH-1:BYTE_SH];

    ifu_imem #(
        .DATA_W (XLEN),
        .DEPTH  (IMEM_WORDS)
    ) u_imem (
        .clk     (clk),
        .wr_en   (pre_we),
        .wr_idx  (pre_addr),
        .wr_data (pre_data),
        .rd_idx  (fetch_idx),
        .rd_data (instr_o)
    );

    ifu_next_addr u_nxt (
        .pc      (pc_o),
        .offset  (instr_o[OFF_W-1:0]),
        .br_sel  (br_sel),
        .eq_flag (eq_flag),
        .nxt     (nxt)
    );

    always_comb begin
        unique case (nxt.sel)
            NXT_BR:  pc_d = nxt.br_addr;
            default: pc_d = nxt.seq_addr;
        endcase
    end

    ifu_pc_reg #(
        .W (XLEN)
    ) u_pc (
        .clk (clk),
        .rst (rst),
        .d   (pc_d),
        .q   (pc_o)
    );

endmodule

// File: rtl/ifetch_unit_chk.sv
module ifetch_unit_chk
    import ifu_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            br_sel,
    input logic            eq_flag,
    input logic [XLEN-1:0] pc_o,
    input logic [XLEN-1:0] instr_o
);

    // R5
    pc_reset_chk: assert property (@(posedge clk)
        rst |=> pc_o == '0);

    // R2
    pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
        !(br_sel && eq_flag) |=> pc_o == $past(pc_o) + XLEN'(WORD_B));

    // R3
    pc_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (br_sel && eq_flag) |=>
            pc_o == $past(pc_o) + XLEN'(WORD_B) + br_disp($past(instr_o[OFF_W-1:0])));

    // R6
    pc_align_chk: assert property (@(posedge clk) disable iff (rst)
        pc_o[BYTE_SH-1:0] == '0);

endmodule

bind ifetch_unit ifetch_unit_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .br_sel  (br_sel),
    .eq_flag (eq_flag),
    .pc_o    (pc_o),
    .instr_o (instr_o)
);

// File: tb/ifetch_unit_bench.sv
module ifetch_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_sel = 1'b0;
    logic        eq_flag = 1'b0;
    logic        pre_we = 1'b0;
    logic [7:0]  pre_addr = '0;
    logic [31:0] pre_data = '0;
    logic [31:0] pc_o;
    logic [31:0] instr_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] mdl_mem [256];
    logic [31:0] mpc;

    always #10 clk = ~clk;

    ifetch_unit u_ifetch_unit (
        .clk      (clk),
        .rst      (rst),
        .br_sel   (br_sel),
        .eq_flag  (eq_flag),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .pc_o     (pc_o),
        .instr_o  (instr_o)
    );

    // {br_sel, eq_flag} per cycle
    localparam logic [1:0] VEC [24] = '{
        2'b00, 2'b11, 2'b10, 2'b01, 2'b11, 2'b00, 2'b11, 2'b11,
        2'b10, 2'b01, 2'b00, 2'b11, 2'b11, 2'b00, 2'b10, 2'b11,
        2'b01, 2'b11, 2'b00, 2'b00, 2'b11, 2'b10, 2'b11, 2'b01
    };

    function automatic logic [31:0] fill_word(input int i);
        logic [15:0] off;
        if (i % 3 == 0) off = 16'hFFF9;
        else            off = 16'h0005;
        return {i[7:0], 8'hC3, off};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    // Called at a falling edge; applies one cycle and checks at the next falling edge.
    task automatic step(input logic b, input logic e, input string tag);
        logic [31:0] w;
        w       = mdl_mem[mpc[9:2]];
        br_sel  = b;
        eq_flag = e;
        if (b && e) mpc = mpc + 32'd4 + {{14{w[15]}}, w[15:0], 2'b00};
        else        mpc = mpc + 32'd4;
        @(posedge clk);
        @(negedge clk);
        chk(tag, pc_o, mpc);
        chk("R6", {30'd0, pc_o[1:0]}, 32'd0);
        chk("R1", instr_o, mdl_mem[mpc[9:2]]);
    endtask

    task automatic preload(input int idx, input logic [31:0] val);
        pre_we   = 1'b1;
        pre_addr = idx[7:0];
        pre_data = val;
        mdl_mem[idx] = val;
        @(posedge clk);
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mpc = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        mpc = '0;
        @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            preload(i, fill_word(i));
        end
        // R5: reset state
        chk("R5", pc_o, 32'd0);
        chk("R1", instr_o, mdl_mem[0]);

        // R7: disabled write port leaves the word unchanged
        pre_we   = 1'b0;
        pre_addr = 8'd0;
        pre_data = 32'hDEAD_BEEF;
        @(posedge clk);
        @(negedge clk);
        chk("R7", instr_o, mdl_mem[0]);

        // R2 R3 R4 R8: vector walk, model-computed targets (offsets 0xFFF9 go backward)
        rst = 1'b0;
        for (int v = 0; v < 24; v++) begin
            if (VEC[v] == 2'b11)      step(VEC[v][1], VEC[v][0], "R3");
            else if (VEC[v] == 2'b00) step(VEC[v][1], VEC[v][0], "R2");
            else                      step(VEC[v][1], VEC[v][0], "R4");
        end

        // R5: reset wins over a taken branch from a nonzero PC
        br_sel  = 1'b1;
        eq_flag = 1'b1;
        do_reset();
        chk("R5", pc_o, 32'd0);

        // R7 R9: word 0 holds offset 0x00FF, target is 1024 bytes ahead
        br_sel  = 1'b0;
        eq_flag = 1'b0;
        preload(0, 32'h1234_00FF);
        chk("R7", instr_o, 32'h1234_00FF);
        rst = 1'b0;
        step(1'b1, 1'b1, "R9");
        chk("R9", pc_o, 32'd1024);
        chk("R9", instr_o, 32'h1234_00FF);

        // R8: offset 0xFFFF branches back to itself
        do_reset();
        preload(0, 32'hBEEF_FFFF);
        rst = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 1'b1, "R8");
            chk("R8", pc_o, 32'd0);
        end
        step(1'b0, 1'b1, "R4");
        chk("R4", pc_o, 32'd4);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule